// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block sits beside a dual-clock FIFO and produces its two early-warning flags. It holds an empty-side threshold X and a full-side threshold Y. On every read-clock edge it compares the stored-word count against X and drives an active-LOW almost-empty flag. On every write-clock edge it compares the free-location count against Y and drives an active-LOW almost-full flag. Both counts come from the FIFO's pointer logic and arrive already synchronized into the matching clock domain.

The thresholds are set up in one of three ways, chosen by mode pins while the main reset is held and fixed when it is released:
- a preset value of 8, 16 or 64, written into both thresholds;
- two parallel writes taken from the write-side data bus;
- a serial bit stream shifted in on the write clock.

A small state machine in the write domain tracks the programming and raises a done output when the thresholds are final. A partial reset clears the flags but keeps the chosen method and the threshold values.

The state machine has four states:
- `ST_LOAD_Y`: waiting for the first parallel write.
- `ST_LOAD_X`: waiting for the second parallel write.
- `ST_SHIFT`: taking serial bits.
- `ST_DONE`: thresholds final.

While `rst_n` is LOW the state is loaded on every write-clock edge from the mode pins:
- `ser_mode_n` LOW loads `ST_SHIFT`.
- `fsel`=11 loads `ST_LOAD_Y`.
- Any other `fsel` code loads `ST_DONE`.

After release the transitions are:
- `ST_LOAD_Y`→`ST_LOAD_X` on `a_wr`.
- `ST_LOAD_X`→`ST_DONE` on `a_wr`.
- `ST_SHIFT`→`ST_DONE` on the last serial bit.
- `ST_DONE` is held until the next main reset.

Top module: `almost_flag_unit`

## Requirements
- R1: `ae_n` is updated on each rising `rclk` edge to 0 when `fill_cnt` sampled at that edge is less than or equal to X, and to 1 otherwise.
- R2: `af_n` is updated on each rising `wclk` edge to 0 when `free_cnt` sampled at that edge is less than or equal to Y, and to 1 otherwise.
- R3: The mode pins are sampled while `rst_n` is LOW. With `ser_mode_n`=1, the `fsel` codes 00, 01 and 10 set both X and Y to 64, 16 and 8 respectively, and `prog_done` is 1 immediately after release.
- R4: With `ser_mode_n`=1 and `fsel`=11 (parallel load), the first `a_wr` after release loads Y from `a_data[OW-1:0]`, where OW is log2(DEPTH). The second `a_wr` loads X from the same bits and raises `prog_done`. Any later writes leave X and Y unchanged.
- R5: With `ser_mode_n`=0 (serial load), each rising `wclk` edge with `ser_en_n`=0 shifts `ser_dat` into the LSB of the concatenation {Y,X}. After 2·OW bits the first bit sits in the MSB of Y and the last bit in the LSB of X. An edge with `ser_en_n`=1 shifts nothing.
- R6: `prog_done` rises on the edge that takes the 2·OW-th serial bit. From then on, serial pulses leave X and Y unchanged until the next main reset.
- R7: While `prst_n` is LOW, both flags are driven to 0 on their clock edges. After `prst_n` is released, the programming method, X, Y and `prog_done` are unchanged.
- R8: While `rst_n` is LOW, both flags are driven to 0 on their clock edges, whatever the counts.
- R9: Inputs belonging to another programming method have no effect. `a_wr` is ignored in serial mode, and serial pulses and `a_wr` are ignored in preset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; drives programming and almost-full |
| rclk | input | 1 | Read-side clock; drives almost-empty |
| rst_n | input | 1 | Main reset, active LOW; mode pins are sampled while it is LOW |
| prst_n | input | 1 | Partial reset, active LOW; keeps method and thresholds |
| ser_mode_n | input | 1 | LOW selects serial threshold loading |
| fsel | input | 2 | Preset/parallel code: 00=64, 01=16, 10=8, 11=parallel |
| ser_en_n | input | 1 | Serial shift enable, active LOW |
| ser_dat | input | 1 | Serial threshold data bit |
| a_wr | input | 1 | Write strobe of the write-side data bus |
| a_data | input | DW | Write-side data bus |
| fill_cnt | input | OW+1 | Stored-word count, synchronized to rclk |
| free_cnt | input | OW+1 | Free-location count, synchronized to wclk |
| ae_n | output | 1 | Almost-empty flag, active LOW |
| af_n | output | 1 | Almost-full flag, active LOW |
| prog_done | output | 1 | Thresholds are final |

## Verification
The thresholds cannot be read from the ports. The only view of them is where each flag switches as its count moves. The bench therefore sweeps each count across its whole range, 0 to DEPTH, after every programming sequence and after each disturbance. It compares every step with the threshold it computes from the values it sent in.

The hardest point to reach is a serial load with idle gaps, a stray parallel write, a partial reset and extra pulses after completion. The bench builds exactly that sequence and then sweeps both counts again.

// File: rtl/almost_flag_pkg.sv
package almost_flag_pkg;

    typedef enum logic [1:0] {
        ST_LOAD_Y,
        ST_LOAD_X,
        ST_SHIFT,
        ST_DONE
    } cfg_state_e;

    // Preset threshold for an fsel code; 0 for the parallel code.
    function automatic int unsigned preset_off(input logic [1:0] fs);
        unique case (fs)
            2'b00:   return 64;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 0;
        endcase
    endfunction

    // State entered at release of the main reset.
    function automatic cfg_state_e start_state(input logic ser_mode_n, input logic [1:0] fs);
        if (!ser_mode_n)     return ST_SHIFT;
        else if (fs == 2'b11) return ST_LOAD_Y;
        else                 return ST_DONE;
    endfunction

endpackage

// File: rtl/almost_cfg_fsm.sv
module almost_cfg_fsm
    import almost_flag_pkg::*;
#(
    parameter int OW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          ser_mode_n,
    input  logic [1:0]    fsel,
    input  logic          ser_en_n,
    input  logic          ser_dat,
    input  logic          a_wr,
    input  logic [DW-1:0] a_data,
    output logic [OW-1:0] x_off,
    output logic [OW-1:0] y_off,
    output logic          prog_done
);
    localparam int SER_BITS = 2 * OW;
    localparam int CNT_W    = $clog2(SER_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SER_BITS - 1);

    cfg_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [2*OW-1:0]  shreg;
    logic             shift_now;

    assign shreg     = {y_off, x_off};
    assign shift_now = (state_q == ST_SHIFT) && !ser_en_n;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD_Y: if (a_wr) state_d = ST_LOAD_X;
            ST_LOAD_X: if (a_wr) state_d = ST_DONE;
            ST_SHIFT:  if (shift_now && bit_cnt_q == LAST_BIT) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
        endcase
    end

    // State register; mode pins sampled while main reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) state_q <= start_state(ser_mode_n, fsel);
        else        state_q <= state_d;
    end

    // Threshold and bit-count registers
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            x_off     <= OW'(preset_off(fsel));
            y_off     <= OW'(preset_off(fsel));
            bit_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD_Y: if (a_wr) y_off <= a_data[OW-1:0];
                ST_LOAD_X: if (a_wr) x_off <= a_data[OW-1:0];
                ST_SHIFT: if (shift_now) begin
                    {y_off, x_off} <= {shreg[2*OW-2:0], ser_dat};
                    bit_cnt_q      <= bit_cnt_q + 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        prog_done = (state_q == ST_DONE);
    end

endmodule

// File: rtl/almost_flag_reg.sv
module almost_flag_reg #(
    parameter int OW = 8,
    parameter int CW = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic [CW-1:0] level,
    input  logic [OW-1:0] offset,
    output logic          flag_n
);
    logic [CW-1:0] off_ext;
    assign off_ext = CW'(offset);

    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) flag_n <= 1'b0;
        else                   flag_n <= (level > off_ext);
    end
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit #(
    parameter int DEPTH = 256,
    parameter int DW    = 36,
    localparam int OW   = $clog2(DEPTH),
    localparam int CW   = OW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          ser_mode_n,
    input  logic [1:0]    fsel,
    input  logic          ser_en_n,
    input  logic          ser_dat,
    input  logic          a_wr,
    input  logic [DW-1:0] a_data,
    input  logic [CW-1:0] fill_cnt,
    input  logic [CW-1:0] free_cnt,
    output logic          ae_n,
    output logic          af_n,
    output logic          prog_done
);
    logic [OW-1:0] x_off;
    logic [OW-1:0] y_off;

    almost_cfg_fsm #(.OW(OW), .DW(DW)) u_cfg (
        .wclk(wclk), .rst_n(rst_n), .ser_mode_n(ser_mode_n), .fsel(fsel),
        .ser_en_n(ser_en_n), .ser_dat(ser_dat), .a_wr(a_wr), .a_data(a_data),
        .x_off(x_off), .y_off(y_off), .prog_done(prog_done)
    );

    almost_flag_reg #(.OW(OW), .CW(CW)) u_empty_side (
        .clk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .level(fill_cnt), .offset(x_off), .flag_n(ae_n)
    );

    almost_flag_reg #(.OW(OW), .CW(CW)) u_full_side (
        .clk(wclk), .rst_n(rst_n), .prst_n(prst_n),
        .level(free_cnt), .offset(y_off), .flag_n(af_n)
    );
endmodule

// File: rtl/almost_flag_checker.sv
module almost_flag_checker #(
    parameter int OW = 8,
    parameter int CW = OW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          prst_n,
    input logic          ser_mode_n,
    input logic [1:0]    fsel,
    input logic [CW-1:0] fill_cnt,
    input logic [CW-1:0] free_cnt,
    input logic [OW-1:0] x_off,
    input logic [OW-1:0] y_off,
    input logic          ae_n,
    input logic          af_n,
    input logic          prog_done
);
    logic [CW-1:0] x_ext, y_ext;
    assign x_ext = CW'(x_off);
    assign y_ext = CW'(y_off);

    a_r1_empty_flag: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        $past(rst_n && prst_n) |-> (ae_n == ($past(fill_cnt) > $past(x_ext))));

    a_r2_full_flag: assert property (@(posedge wclk) disable iff (!rst_n || !prst_n)
        $past(rst_n && prst_n) |-> (af_n == ($past(free_cnt) > $past(y_ext))));

    a_r3_preset_done: assert property (@(posedge wclk) disable iff (!rst_n)
        ($past(!rst_n) && $past(ser_mode_n) && $past(fsel) != 2'b11) |-> prog_done);

    a_r6_done_holds: assert property (@(posedge wclk) disable iff (!rst_n)
        prog_done |=> prog_done);

    a_r6_frozen: assert property (@(posedge wclk) disable iff (!rst_n)
        prog_done |=> ($stable(x_off) && $stable(y_off)));

    a_r7_partial_low: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(!prst_n) |-> !af_n);

    a_r8_reset_low_w: assert property (@(posedge wclk) disable iff (!prst_n)
        $past(!rst_n) |-> !af_n);

    a_r8_reset_low_r: assert property (@(posedge rclk) disable iff (!prst_n)
        $past(!rst_n) |-> !ae_n);
endmodule

bind almost_flag_unit almost_flag_checker #(.OW(OW), .CW(CW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
    .ser_mode_n(ser_mode_n), .fsel(fsel), .fill_cnt(fill_cnt), .free_cnt(free_cnt),
    .x_off(x_off), .y_off(y_off), .ae_n(ae_n), .af_n(af_n), .prog_done(prog_done)
);

// File: tb/test_almost_flag_unit.sv
`timescale 1ns/1ps
module test_almost_flag_unit;
    localparam int DEPTH = 256;
    localparam int DW    = 36;
    localparam int OW    = $clog2(DEPTH);
    localparam int CW    = OW + 1;

    logic wclk = 0, rclk = 0;
    logic rst_n = 0, prst_n = 1, ser_mode_n = 1, ser_en_n = 1, ser_dat = 0, a_wr = 0;
    logic [1:0]    fsel = 2'b00;
    logic [DW-1:0] a_data = '0;
    logic [CW-1:0] fill_cnt = '0, free_cnt = '0;
    logic ae_n, af_n, prog_done;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    almost_flag_unit #(.DEPTH(DEPTH), .DW(DW)) i_almost_flag_unit (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .ser_mode_n(ser_mode_n), .fsel(fsel), .ser_en_n(ser_en_n), .ser_dat(ser_dat),
        .a_wr(a_wr), .a_data(a_data), .fill_cnt(fill_cnt), .free_cnt(free_cnt),
        .ae_n(ae_n), .af_n(af_n), .prog_done(prog_done)
    );

    task automatic chk(input string rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    // R1: sweep fill count over 0..DEPTH against threshold x
    task automatic sweep_ae(input int x, input string rq);
        @(negedge rclk);
        for (int c = 0; c <= DEPTH; c++) begin
            fill_cnt = CW'(c);
            @(posedge rclk); @(negedge rclk);
            chk(rq, ae_n, (c <= x) ? 1'b0 : 1'b1);
        end
    endtask

    // R2: sweep free count over 0..DEPTH against threshold y
    task automatic sweep_af(input int y, input string rq);
        @(negedge wclk);
        for (int c = 0; c <= DEPTH; c++) begin
            free_cnt = CW'(c);
            @(posedge wclk); @(negedge wclk);
            chk(rq, af_n, (c <= y) ? 1'b0 : 1'b1);
        end
    endtask

    // R8: flags low during main reset with counts that would give 1
    task automatic do_reset(input logic sm_n, input logic [1:0] fs);
        @(negedge wclk);
        rst_n = 0; ser_mode_n = sm_n; fsel = fs;
        fill_cnt = CW'(DEPTH); free_cnt = CW'(DEPTH);
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        chk("R8 af_n in reset", af_n, 1'b0);
        chk("R8 ae_n in reset", ae_n, 1'b0);
        rst_n = 1;
    endtask

    task automatic pwrite(input logic [DW-1:0] d);
        @(negedge wclk); a_wr = 1; a_data = d;
        @(negedge wclk); a_wr = 0; a_data = '0;
    endtask

    task automatic sbit(input logic b, input logic en_n);
        @(negedge wclk); ser_en_n = en_n; ser_dat = b;
        @(negedge wclk); ser_en_n = 1; ser_dat = 0;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R3: preset codes
        for (int code = 0; code < 3; code++) begin
            int p;
            p = (code == 0) ? 64 : (code == 1) ? 16 : 8;
            do_reset(1'b1, 2'(code));
            @(negedge wclk);
            chk("R3 preset done", prog_done, 1'b1);
            sweep_ae(p, "R1/R3 preset X");
            sweep_af(p, "R2/R3 preset Y");
            // R9: foreign inputs in preset mode
            sbit(1'b1, 1'b0); sbit(1'b1, 1'b0);
            pwrite(36'h0_0000_00FF);
            sweep_ae(p, "R9 preset X unchanged");
            sweep_af(p, "R9 preset Y unchanged");
        end

        // R4: parallel load, Y=0x25 then X=0xC8, upper bits noise
        do_reset(1'b1, 2'b11);
        @(negedge wclk);
        chk("R4 parallel not done", prog_done, 1'b0);
        pwrite(36'hABCDE_F025);
        chk("R4 done after one write", prog_done, 1'b0);
        pwrite(36'h12345_67C8);
        chk("R4 done after two writes", prog_done, 1'b1);
        pwrite(36'hFFFFF_FF03);
        sweep_ae(200, "R1/R4 parallel X");
        sweep_af(37, "R2/R4 parallel Y");

        // R5/R6/R9: serial load {Y,X} = {0xA5,0x3C}, MSB first, with gaps
        do_reset(1'b0, 2'b11);
        begin
            logic [2*OW-1:0] word;
            word = {8'hA5, 8'h3C};
            for (int i = 2*OW-1; i >= 0; i--) begin
                if (i == 9) begin
                    sbit(1'b1, 1'b1);
                    sbit(1'b0, 1'b1);
                    pwrite(36'h0_0000_00FF);
                    chk("R5 no shift while disabled", prog_done, 1'b0);
                end
                sbit(word[i], 1'b0);
                if (i == 1) chk("R6 not done before last bit", prog_done, 1'b0);
            end
            chk("R6 done after last bit", prog_done, 1'b1);
            for (int k = 0; k < 4; k++) sbit(1'b1, 1'b0);
            chk("R6 done stays", prog_done, 1'b1);
        end
        sweep_ae(60, "R1/R5/R6 serial X");
        sweep_af(165, "R2/R5/R6 serial Y");

        // R7: partial reset keeps thresholds
        @(negedge wclk);
        fill_cnt = CW'(DEPTH); free_cnt = CW'(DEPTH);
        repeat (2) @(negedge rclk);
        chk("R7 ae_n before prst", ae_n, 1'b1);
        @(negedge wclk); prst_n = 0;
        repeat (3) @(negedge wclk);
        repeat (3) @(negedge rclk);
        @(negedge wclk);
        chk("R7 af_n low in prst", af_n, 1'b0);
        chk("R7 ae_n low in prst", ae_n, 1'b0);
        prst_n = 1;
        repeat (2) @(negedge wclk);
        repeat (2) @(negedge rclk);
        @(negedge wclk);
        chk("R7 done kept", prog_done, 1'b1);
        sweep_ae(60, "R7 X kept");
        sweep_af(165, "R7 Y kept");

        // R8: main reset reselects method (back to preset 8)
        do_reset(1'b1, 2'b10);
        sweep_ae(8, "R8 reprogram X");
        sweep_af(8, "R8 reprogram Y");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule